// File: doc/BRIEF.md
# Descriptor-Driven PCIe Configuration Access Bridge

This block sits between a host processor's register bus and a downstream PCIe configuration-access port. Software does not drive configuration cycles directly. It first loads a small set of packet-style descriptor words and a write-data word into a 64-word register window. It then sets a one-shot trigger bit. The bridge takes a snapshot of the descriptors and decodes the format/type code, the target bus, the device/function and the register offset. It then issues exactly one request on a valid/ready port and waits for the matching response.

When the response arrives, read data goes into a per-port result register. A target that does not answer leaves all ones in that register. The bridge then raises three status flags: a completion flag, an idle flag and a write-1-to-clear done flag. Software polls these flags and clears them through side-effect registers.

On the root port, bus numbers start at a configurable value (0x80 by default) rather than at 0. A request aimed at that bus number is therefore sent downstream as bus 0.

Top module: `pcie_cfg_bridge`

## Requirements
- R1: After reset every register reads zero. Writes to registers with no side effect store the value, and every read returns the stored word.
- R2: A write to the control word (byte 0x00) with bit 4 set loads all ones into the common read-data word (0x0C). A write with bit 4 clear leaves 0x0C unchanged. The control word itself keeps no written value.
- R3: A write with bit 0 set to the idle-clear word (0x08) clears bit 31 (idle) of the transmit-status word (0x24) and leaves bit 25 unchanged.
- R4: A write with bit 0 set to 0x24 launches one request from the current descriptors, which sit at 0x10, 0x14, 0x18 and 0x1C, with the write data at 0x20. The request carries:
  - bus = 0x18[31:24];
  - device/function = 0x18[23:16];
  - dword offset = 0x18[11:2];
  - data = 0x20;
  - byte enables = 0x14[3:0] for a write, and 4'hF for a read.
- R5: Format/type codes 0x04 and 0x05 in 0x10[31:24] issue a read (write flag 0). The returned data is stored in the port read-data word at 0xCC.
- R6: Codes 0x44 and 0x45 issue a write (write flag 1). A present target leaves 0xCC unchanged.
- R7: When the descriptor bus equals ROOT_BUS (0x80), the request goes out with bus 0. Any other bus value passes unchanged.
- R8: A response flagged not-present loads all ones into 0xCC, for both reads and writes.
- R9: Any other format/type code produces no downstream request, and the transaction still completes.
- R10: On completion, the bridge sets bit 4 (done) of the interrupt-status word at 0xC8, and bits 25 (completion) and 31 (idle) of 0x24.
- R11: A write to 0xC8 clears each written-one bit above bit 3 and never changes bits [3:0]. Writing 1 to bit 4 also clears bit 25 of 0x24.
- R12: A trigger that arrives while a transaction is outstanding is ignored. The request fields stay stable while the valid signal waits for the ready signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_word | input | 6 | Register word index (byte offset / 4) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Stored value of the addressed word |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_bus | output | 8 | Target bus after root remap |
| req_devfn | output | 8 | Target device/function |
| req_offset | output | 10 | Dword register offset |
| req_write | output | 1 | 1 = configuration write |
| req_be | output | 4 | Byte enables |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Response valid |
| rsp_data | input | 32 | Response read data |
| rsp_absent | input | 1 | No device answered |

## Verification
Several properties are checked on every cycle:
- the request fields hold while valid waits for ready;
- the root bus number never appears on the request port;
- an unknown code never leads to a request;
- every completion raises all three status flags;
- a write to the interrupt-status word never changes its low four bits.

Other behaviour can only be shown by the directed scenarios: the field decode, the data that lands in the result words, the side effects of the control and clear words, and the fact that a second trigger yields no second request.

// File: rtl/pcie_cfg_bridge.sv
module pcie_cfg_bridge #(
  parameter logic [7:0] ROOT_BUS = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_word,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [7:0]  req_bus,
  output logic [7:0]  req_devfn,
  output logic [9:0]  req_offset,
  output logic        req_write,
  output logic [3:0]  req_be,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_data,
  input  logic        rsp_absent
);
  localparam int NWORDS  = 64;
  localparam int W_CTRL  = 0;
  localparam int W_ICLR  = 2;
  localparam int W_CRD   = 3;
  localparam int W_D0    = 4;
  localparam int W_D1    = 5;
  localparam int W_D2    = 6;
  localparam int W_WDAT  = 8;
  localparam int W_TXS   = 9;
  localparam int W_ISTS  = 50;
  localparam int W_PRD   = 51;
  localparam int B_DONE  = 4;
  localparam int B_COMP  = 25;
  localparam int B_IDLE  = 31;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_FIN} st_t;

  logic [31:0] regs [NWORDS];
  st_t         state;
  logic [7:0]  q_bus, q_devfn;
  logic [9:0]  q_off;
  logic        q_wr;
  logic [3:0]  q_be;
  logic [31:0] q_data;

  wire [7:0] fmt    = regs[W_D0][31:24];
  wire       is_rd  = (fmt == 8'h04) || (fmt == 8'h05);
  wire       is_wr  = (fmt == 8'h44) || (fmt == 8'h45);
  wire [7:0] d_bus  = regs[W_D2][31:24];
  wire       trig   = cfg_we && (cfg_word == 6'(W_TXS)) && cfg_wdata[0];
  wire       launch = trig && (state == S_IDLE);
  wire       got    = (state == S_RSP) && rsp_valid;
  wire       finish = got || (state == S_FIN);

  assign cfg_rdata  = regs[cfg_word];
  assign req_valid  = (state == S_REQ);
  assign req_bus    = q_bus;
  assign req_devfn  = q_devfn;
  assign req_offset = q_off;
  assign req_write  = q_wr;
  assign req_be     = q_be;
  assign req_wdata  = q_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (launch) state <= (is_rd || is_wr) ? S_REQ : S_FIN;
        S_REQ:  if (req_ready) state <= S_RSP;
        S_RSP:  if (rsp_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_bus   <= '0;
      q_devfn <= '0;
      q_off   <= '0;
      q_wr    <= 1'b0;
      q_be    <= '0;
      q_data  <= '0;
    end else if (launch) begin
      q_bus   <= (d_bus == ROOT_BUS) ? 8'h00 : d_bus;
      q_devfn <= regs[W_D2][23:16];
      q_off   <= regs[W_D2][11:2];
      q_wr    <= is_wr;
      q_be    <= is_wr ? regs[W_D1][3:0] : 4'hF;
      q_data  <= regs[W_WDAT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i] <= '0;
    end else begin
      if (cfg_we) begin
        case (int'(cfg_word))
          W_CTRL: if (cfg_wdata[4]) regs[W_CRD] <= '1;
          W_ICLR: if (cfg_wdata[0]) regs[W_TXS][B_IDLE] <= 1'b0;
          W_TXS:  ;
          W_ISTS: begin
            regs[W_ISTS] <= regs[W_ISTS] & (~cfg_wdata | 32'h0000_000F);
            if (cfg_wdata[B_DONE]) regs[W_TXS][B_COMP] <= 1'b0;
          end
          default: regs[cfg_word] <= cfg_wdata;
        endcase
      end
      if (finish) begin
        regs[W_ISTS][B_DONE] <= 1'b1;
        regs[W_TXS][B_COMP]  <= 1'b1;
        regs[W_TXS][B_IDLE]  <= 1'b1;
        if (got) begin
          if (rsp_absent)  regs[W_PRD] <= '1;
          else if (!q_wr)  regs[W_PRD] <= rsp_data;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid &&
      $stable({req_bus, req_devfn, req_offset, req_write, req_be, req_wdata})); // R12

  AST_NO_ROOT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_bus != ROOT_BUS); // R7

  AST_BAD_CODE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !(is_rd || is_wr) |=> !req_valid); // R9

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> regs[W_TXS][B_IDLE] && regs[W_TXS][B_COMP] && regs[W_ISTS][B_DONE]); // R10

  AST_INTX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_word == 6'(W_ISTS) |=> regs[W_ISTS][3:0] == $past(regs[W_ISTS][3:0])); // R11

endmodule

// File: tb/test_pcie_cfg_bridge.sv
module test_pcie_cfg_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_word = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid, req_ready = 1'b0;
  logic [7:0] req_bus, req_devfn;
  logic [9:0] req_offset;
  logic req_write;
  logic [3:0] req_be;
  logic [31:0] req_wdata;
  logic rsp_valid = 1'b0, rsp_absent = 1'b0;
  logic [31:0] rsp_data = '0;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pcie_cfg_bridge i_pcie_cfg_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_bus(req_bus), .req_devfn(req_devfn),
    .req_offset(req_offset), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_absent(rsp_absent));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] byte_addr, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_word = byte_addr[7:2]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] byte_addr, output logic [31:0] d);
    cfg_word = byte_addr[7:2];
    #1 d = cfg_rdata;
  endtask

  task automatic setup(input logic [31:0] d0, d1, d2, wd);
    wr(8'h10, d0); wr(8'h14, d1); wr(8'h18, d2); wr(8'h20, wd);
  endtask

  // waits for a request, checks it, optionally stalls with an extra trigger, then responds
  task automatic serve(input string req, input logic [7:0] bus, devfn, input logic [9:0] off,
                       input logic w, input logic [3:0] be, input logic [31:0] wd,
                       input int stall, input logic [31:0] rdat, input logic absent);
    int k = 0;
    while (!req_valid && k < 50) begin @(negedge clk); k++; end
    chk({req, " req_valid"}, {31'd0, req_valid}, 32'd1);
    chk({req, " bus"}, {24'd0, req_bus}, {24'd0, bus});
    chk({req, " devfn"}, {24'd0, req_devfn}, {24'd0, devfn});
    chk({req, " offset"}, {22'd0, req_offset}, {22'd0, off});
    chk({req, " write/be"}, {27'd0, req_write, req_be}, {27'd0, w, be});
    chk({req, " wdata"}, req_wdata, wd);
    if (stall > 0) begin
      wr(8'h24, 32'h1);
      for (int i = 0; i < stall; i++) @(negedge clk);
      chk("R12 held valid", {31'd0, req_valid}, 32'd1);
      chk("R12 held fields", {req_bus, req_devfn, 6'd0, req_offset}, {bus, devfn, 6'd0, off});
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk({req, " valid drops"}, {31'd0, req_valid}, 32'd0);
    rsp_valid = 1'b1; rsp_data = rdat; rsp_absent = absent;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_absent = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 reset ctrl", v, 0);
    rd(8'h24, v); chk("R1 reset txsts", v, 0);
    rd(8'hC8, v); chk("R1 reset ists", v, 0);
    rd(8'hCC, v); chk("R1 reset prdata", v, 0);
    rd(8'h40, v); chk("R1 reset plain", v, 0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(8'h40, 32'hA5A5_0F0F); rd(8'h40, v); chk("R1 plain store", v, 32'hA5A5_0F0F);
    wr(8'hC0, 32'h1357_9BDF); rd(8'hC0, v); chk("R1 port ctrl store", v, 32'h1357_9BDF);
    wr(8'h0C, 32'h0000_0055); rd(8'h0C, v); chk("R1 rdata store", v, 32'h55);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(8'h00, 32'h0000_000F); rd(8'h0C, v); chk("R2 no bit4 keeps", v, 32'h55);
    wr(8'h00, 32'h0000_0010); rd(8'h0C, v); chk("R2 bit4 ones", v, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 ctrl not stored", v, 0);
  endtask

  task automatic t_read_remap();
    logic [31:0] v;
    setup(32'h0400_0000, 32'h0000_0000, 32'h8018_00A8, 32'h1111_2222);
    rd(8'h10, v); chk("R1 desc stored", v, 32'h0400_0000);
    wr(8'h24, 32'h1);
    serve("R4 R5 R7 read", 8'h00, 8'h18, 10'h2A, 1'b0, 4'hF, 32'h1111_2222, 0, 32'hDEAD_BEEF, 1'b0);
    rd(8'hCC, v); chk("R5 read data", v, 32'hDEAD_BEEF);
    rd(8'h24, v); chk("R10 txsts flags", v, 32'h8200_0000);
    rd(8'hC8, v); chk("R10 done", v, 32'h10);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'hC8, 32'h0000_000F); rd(8'hC8, v); chk("R11 low bits no clear", v, 32'h10);
    wr(8'h08, 32'h1); rd(8'h24, v); chk("R3 idle cleared", v, 32'h0200_0000);
    wr(8'hC8, 32'hFFFF_FFF0); rd(8'hC8, v); chk("R11 done w1c", v, 0);
    rd(8'h24, v); chk("R11 comp cleared", v, 0);
  endtask

  task automatic t_write_stall();
    logic [31:0] v;
    setup(32'h4500_0000, 32'h0000_0003, 32'h0521_0010, 32'hCAFE_1234);
    wr(8'h24, 32'h1);
    serve("R4 R6 R7 write", 8'h05, 8'h21, 10'h004, 1'b1, 4'h3, 32'hCAFE_1234, 3, 32'h0BAD_0BAD, 1'b0);
    rd(8'hCC, v); chk("R6 write leaves prdata", v, 32'hDEAD_BEEF);
    rd(8'h24, v); chk("R10 write flags", v, 32'h8200_0000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R12 second trigger ignored", {31'd0, req_valid}, 32'd0);
    end
  endtask

  task automatic t_absent();
    logic [31:0] v;
    wr(8'hC8, 32'h10); wr(8'h08, 32'h1);
    setup(32'h0500_0000, 32'h0, 32'h03FF_0FFC, 32'h0);
    wr(8'h24, 32'h1);
    serve("R5 R7 absent read", 8'h03, 8'hFF, 10'h3FF, 1'b0, 4'hF, 32'h0, 0, 32'h1234_5678, 1'b1);
    rd(8'hCC, v); chk("R8 absent read ones", v, 32'hFFFF_FFFF);
    wr(8'hCC, 32'h0); wr(8'hC8, 32'h10);
    setup(32'h4400_0000, 32'h0000_000F, 32'h8000_0004, 32'h5A5A_5A5A);
    wr(8'h24, 32'h1);
    serve("R6 R7 absent write", 8'h00, 8'h00, 10'h001, 1'b1, 4'hF, 32'h5A5A_5A5A, 0, 32'h0, 1'b1);
    rd(8'hCC, v); chk("R8 absent write ones", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_badcode();
    logic [31:0] v;
    wr(8'hC8, 32'h10); wr(8'h08, 32'h1);
    rd(8'h24, v); chk("R3 R11 cleared before", v, 0);
    wr(8'hCC, 32'h7777_7777);
    setup(32'h2000_0000, 32'h0, 32'h0100_0000, 32'h0);
    wr(8'h24, 32'h1);
    for (int i = 0; i < 4; i++) begin
      chk("R9 no request", {31'd0, req_valid}, 32'd0);
      @(negedge clk);
    end
    rd(8'h24, v); chk("R9 completes", v, 32'h8200_0000);
    rd(8'hC8, v); chk("R9 done", v, 32'h10);
    rd(8'hCC, v); chk("R9 prdata kept", v, 32'h7777_7777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_ctrl();
    t_read_remap();
    t_clear();
    t_write_stall();
    t_absent();
    t_badcode();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule